// File: doc/BRIEF.md
# Cross-Coupled Current-Sharing Regulator

This block is a fixed-point digital regulator for two converter modules whose inputs are stacked in series and whose outputs are tied in parallel. It has one outer voltage PI loop and two inner current PI loops. The outer loop compares the sampled output voltage with a set point and produces one current reference, which both inner loops use. Each inner loop produces a duty word for a PWM generator.

The current feedback is crossed. The regulator that drives module 1 is fed with module 2's sensed current, and the regulator that drives module 2 is fed with module 1's current. When one module's stacked input voltage rises, the cross-coupled loops push that module's duty up. This draws the two input voltages back to equal, so no input-voltage loop is needed.

Samples arrive with a one-cycle strobe. Two clock edges later, the three results are presented together with a one-cycle valid pulse. All gains and feedback scale factors are parameters held in fixed point with `FRAC` fraction bits. The output limits are programmable at the ports.

Top module: `xshare_ctrl`

## Requirements
- R1: After reset, `iref`, `duty1` and `duty2` are 0 and `out_vld` is low. All integrators are cleared, so the first result after reset is the proportional term alone.
- R2: Each feedback value is floor(sample × K / 2^FRAC), where K is the scale parameter. The defaults are K=26 for voltage and K=13 for both currents, with FRAC=8 (about 0.1 and 0.05).
- R3: The outer loop error is e = `v_ref` − voltage feedback. The unclamped sum is s = KP_V·e + integrator, held with FRAC fraction bits. `iref` is floor(s / 2^FRAC), limited to [`ref_lo`, `ref_hi`]. The defaults are KP_V=1024 and KI_V=20.
- R4: `duty1` is computed from e = `iref` − (scaled `i_meas2`). `duty2` is computed from e = `iref` − (scaled `i_meas1`). Each inner loop uses the same sum-and-limit rule as R3, with the defaults KP_I=2560 and KI_I=64, limited to [`duty_lo`, `duty_hi`].
- R5: When an integrator is allowed to update, it becomes integrator + KI·e. The new value is limited to [lo·2^FRAC, hi·2^FRAC] of its own loop. The result uses the integrator value held before this update.
- R6: Every result is clamped. A loop is high-saturated when s > hi·2^FRAC, and its result is then exactly hi. It is low-saturated when s < lo·2^FRAC, and its result is then exactly lo.
- R7: A loop's integrator holds its value when the loop is high-saturated and e > 0, or low-saturated and e < 0. When the error reverses, the loop leaves saturation with no stored windup.
- R8: A strobe on `smp_vld` at edge k updates `iref` at edge k. It updates `duty1`, `duty2` and raises `out_vld` for exactly one cycle at edge k+1. Without a strobe, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | One-cycle strobe marking a new set of samples |
| v_ref | input | DW | Output voltage set point, in feedback units (signed) |
| v_meas | input | DW | Sampled output voltage (signed) |
| i_meas1 | input | DW | Sampled current of module 1 (signed) |
| i_meas2 | input | DW | Sampled current of module 2 (signed) |
| ref_lo | input | DW | Lower limit of the current reference and of its integrator |
| ref_hi | input | DW | Upper limit of the current reference and of its integrator |
| duty_lo | input | DW | Lower limit of both duty words and of their integrators |
| duty_hi | input | DW | Upper limit of both duty words and of their integrators |
| iref | output | DW | Shared current reference from the outer loop |
| duty1 | output | DW | Duty command for module 1 |
| duty2 | output | DW | Duty command for module 2 |
| out_vld | output | 1 | One-cycle pulse marking new duty words |

## Verification
The bench first drives a current imbalance with only one module's current non-zero. A design that used each module's own current would produce the two duty values swapped. It then holds a large start-up error long enough to saturate every loop, and releases it with a small reversed error. After release, the reference must equal the bare proportional term. A design with integrator windup, or one that froze the integrator whatever the error sign, would show a large stale offset or stay pinned at the limit. Random samples and random limits are checked against a step-by-step model on each strobe. This exposes truncation that rounds toward zero instead of down, off-by-one saturation thresholds, and a duty stage that uses the previous reference rather than the current one.

// File: rtl/xshare_pkg.sv
package xshare_pkg;
   localparam int XS_DW   = 16;
   localparam int XS_AW   = 48;
   localparam int XS_FRAC = 8;
   localparam int XS_KP_V = 1024;
   localparam int XS_KI_V = 20;
   localparam int XS_KP_I = 2560;
   localparam int XS_KI_I = 64;
   localparam int XS_KS_V = 26;
   localparam int XS_KS_I = 13;
endpackage

// File: rtl/xshare_scale.sv
module xshare_scale #(
   parameter int DW   = 16,
   parameter int AW   = 48,
   parameter int FRAC = 8,
   parameter int KS   = 26
) (
   input  logic signed [DW-1:0] meas,
   output logic signed [DW-1:0] fb
);
   localparam logic signed [AW-1:0] KS_W = AW'(KS);

   if (KS < 0 || KS >= (1 << FRAC)) begin : g_bad_gain
      $error("xshare_scale: KS must attenuate");
   end

   logic signed [AW-1:0] meas_w;
   logic signed [AW-1:0] prod;

   always_comb begin
      meas_w = AW'(meas);
      prod   = meas_w * KS_W;
      fb     = DW'(prod >>> FRAC);
   end

   // R2: attenuating scale never flips sign
   always_comb begin
      a_r2_sign_kept: assert (!(meas >= 0 && fb < 0));
   end
endmodule

// File: rtl/xshare_pi.sv
module xshare_pi #(
   parameter int DW   = 16,
   parameter int AW   = 48,
   parameter int FRAC = 8,
   parameter int KP   = 1024,
   parameter int KI   = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] ref_val,
   input  logic signed [DW-1:0] fb,
   input  logic signed [DW-1:0] lo,
   input  logic signed [DW-1:0] hi,
   output logic signed [DW-1:0] out_q
);
   localparam logic signed [AW-1:0] KP_W = AW'(KP);
   localparam logic signed [AW-1:0] KI_W = AW'(KI);

   if (AW < 2 * DW + FRAC + 4) begin : g_bad_aw
      $error("xshare_pi: accumulator too narrow");
   end
   if (KP < 0 || KI < 0) begin : g_bad_gain
      $error("xshare_pi: gains must be non-negative");
   end

   logic signed [DW:0]   err;
   logic signed [AW-1:0] err_w, lo_s, hi_s, sum, integ_q, integ_raw, integ_d;
   logic                 sat_hi, sat_lo, hold;
   logic signed [DW-1:0] out_d;

   always_comb begin
      err       = (DW+1)'(ref_val) - (DW+1)'(fb);
      err_w     = AW'(err);
      lo_s      = AW'(lo) <<< FRAC;
      hi_s      = AW'(hi) <<< FRAC;
      sum       = err_w * KP_W + integ_q;
      sat_hi    = sum > hi_s;
      sat_lo    = sum < lo_s;
      if (sat_hi)      out_d = hi;
      else if (sat_lo) out_d = lo;
      else             out_d = DW'(sum >>> FRAC);
      hold      = (sat_hi && err > 0) || (sat_lo && err < 0);
      integ_raw = integ_q + err_w * KI_W;
      if (integ_raw > hi_s)      integ_d = hi_s;
      else if (integ_raw < lo_s) integ_d = lo_s;
      else                       integ_d = integ_raw;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q   <= '0;
         integ_q <= '0;
      end else if (en) begin
         out_q <= out_d;
         if (!hold) integ_q <= integ_d;
      end
   end

   // R6: every result lies inside the limits it was computed with
   a_r6_out_limited: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(lo) <= $past(hi)) |-> (out_q >= $past(lo) && out_q <= $past(hi)));
   // R5: a changed integrator lies inside its scaled limits
   a_r5_integ_limited: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en) && $past(lo) <= $past(hi) && integ_q != $past(integ_q))
      |-> (integ_q >= $past(lo_s) && integ_q <= $past(hi_s)));
   // R7: integrator holds while pushed further into saturation
   a_r7_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sat_hi && err > 0) |=> $stable(integ_q));
   a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (en && sat_lo && err < 0) |=> $stable(integ_q));
endmodule

// File: rtl/xshare_ctrl.sv
module xshare_ctrl
   import xshare_pkg::*;
#(
   parameter int DW   = XS_DW,
   parameter int AW   = XS_AW,
   parameter int FRAC = XS_FRAC,
   parameter int KP_V = XS_KP_V,
   parameter int KI_V = XS_KI_V,
   parameter int KP_I = XS_KP_I,
   parameter int KI_I = XS_KI_I,
   parameter int KS_V = XS_KS_V,
   parameter int KS_I = XS_KS_I
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [DW-1:0] v_ref,
   input  logic signed [DW-1:0] v_meas,
   input  logic signed [DW-1:0] i_meas1,
   input  logic signed [DW-1:0] i_meas2,
   input  logic signed [DW-1:0] ref_lo,
   input  logic signed [DW-1:0] ref_hi,
   input  logic signed [DW-1:0] duty_lo,
   input  logic signed [DW-1:0] duty_hi,
   output logic signed [DW-1:0] iref,
   output logic signed [DW-1:0] duty1,
   output logic signed [DW-1:0] duty2,
   output logic                 out_vld
);
   localparam int NMOD = 2;

   if (DW < 4 || FRAC < 1 || FRAC >= DW) begin : g_bad_width
      $error("xshare_ctrl: bad width or fraction setting");
   end

   logic signed [DW-1:0] v_fb;
   logic signed [DW-1:0] i_raw  [NMOD];
   logic signed [DW-1:0] i_fb   [NMOD];
   logic signed [DW-1:0] i_fb_q [NMOD];
   logic signed [DW-1:0] duty_q [NMOD];
   logic                 stage_q;

   assign i_raw[0] = i_meas1;
   assign i_raw[1] = i_meas2;

   xshare_scale #(.DW(DW), .AW(AW), .FRAC(FRAC), .KS(KS_V)) u_vscale (
      .meas(v_meas), .fb(v_fb));

   xshare_pi #(.DW(DW), .AW(AW), .FRAC(FRAC), .KP(KP_V), .KI(KI_V)) u_outer (
      .clk(clk), .rst_n(rst_n), .en(smp_vld), .ref_val(v_ref), .fb(v_fb),
      .lo(ref_lo), .hi(ref_hi), .out_q(iref));

   for (genvar g = 0; g < NMOD; g++) begin : g_mod
      xshare_scale #(.DW(DW), .AW(AW), .FRAC(FRAC), .KS(KS_I)) u_iscale (
         .meas(i_raw[g]), .fb(i_fb[g]));

      always_ff @(posedge clk) begin
         if (!rst_n)       i_fb_q[g] <= '0;
         else if (smp_vld) i_fb_q[g] <= i_fb[g];
      end

      // crossed feedback: each module's loop sees the partner's current
      xshare_pi #(.DW(DW), .AW(AW), .FRAC(FRAC), .KP(KP_I), .KI(KI_I)) u_inner (
         .clk(clk), .rst_n(rst_n), .en(stage_q), .ref_val(iref),
         .fb(i_fb_q[NMOD-1-g]), .lo(duty_lo), .hi(duty_hi), .out_q(duty_q[g]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= 1'b0;
         out_vld <= 1'b0;
      end else begin
         stage_q <= smp_vld;
         out_vld <= stage_q;
      end
   end

   assign duty1 = duty_q[0];
   assign duty2 = duty_q[1];

   // R8: valid pulse only two edges after a strobe
   a_r8_vld_origin: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> $past(smp_vld, 2));
   // R8: duty words hold without a strobe two edges back
   a_r8_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_vld, 2) |-> ($stable(duty1) && $stable(duty2)));
   // R8: reference holds without a strobe
   a_r8_iref_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_vld) |-> $stable(iref));
endmodule

// File: tb/tb_xshare_ctrl.sv
module tb_xshare_ctrl;
   localparam longint F = 8;
   localparam longint KPV = 1024, KIV = 20, KPI = 2560, KII = 64, KSV = 26, KSI = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [15:0] v_ref = '0, v_meas = '0, i_meas1 = '0, i_meas2 = '0;
   logic signed [15:0] ref_lo = -16'sd2000, ref_hi = 16'sd2000;
   logic signed [15:0] duty_lo = -16'sd1000, duty_hi = 16'sd1000;
   logic signed [15:0] iref, duty1, duty2;
   logic out_vld;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   longint m_iv, m_i1, m_i2;
   longint e_iref, e_d1, e_d2;

   always #2.5 clk = ~clk;

   xshare_ctrl dut (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .v_ref(v_ref), .v_meas(v_meas),
      .i_meas1(i_meas1), .i_meas2(i_meas2), .ref_lo(ref_lo), .ref_hi(ref_hi),
      .duty_lo(duty_lo), .duty_hi(duty_hi), .iref(iref), .duty1(duty1),
      .duty2(duty2), .out_vld(out_vld));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R8: actual=%0d cycles expected=<150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string req, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   function automatic longint scl(input longint m, input longint k);
      return (m * k) >>> F;
   endfunction

   task automatic pi_model(input longint r, input longint fb, input longint lo,
                           input longint hi, input longint kp, input longint ki,
                           inout longint integ, output longint o);
      longint e = r - fb;
      longint s = kp * e + integ;
      longint hs = hi * 256;
      longint ls = lo * 256;
      bit shi = s > hs;
      bit slo = s < ls;
      longint n;
      o = shi ? hi : (slo ? lo : (s >>> F));
      if (!((shi && e > 0) || (slo && e < 0))) begin
         n = integ + ki * e;
         if (n > hs) n = hs;
         if (n < ls) n = ls;
         integ = n;
      end
   endtask

   task automatic model_step();
      pi_model(v_ref, scl(v_meas, KSV), ref_lo, ref_hi, KPV, KIV, m_iv, e_iref);
      pi_model(e_iref, scl(i_meas2, KSI), duty_lo, duty_hi, KPI, KII, m_i1, e_d1);
      pi_model(e_iref, scl(i_meas1, KSI), duty_lo, duty_hi, KPI, KII, m_i2, e_d2);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      smp_vld = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_iv = 0; m_i1 = 0; m_i2 = 0;
   endtask

   // inputs already set; strobe, then check results after edge k+1
   task automatic sample(input string req);
      smp_vld = 1'b1;
      @(negedge clk);
      smp_vld = 1'b0;
      @(negedge clk);
      model_step();
      chk({req, " R8 out_vld"}, out_vld, 1);
      chk({req, " R3 iref"}, iref, e_iref);
      chk({req, " R4 duty1"}, duty1, e_d1);
      chk({req, " R4 duty2"}, duty2, e_d2);
   endtask

   initial begin
      void'($urandom(32'd1234));
      do_reset();
      // R1: reset state
      chk("R1 iref", iref, 0);
      chk("R1 duty1", duty1, 0);
      chk("R1 duty2", duty2, 0);
      chk("R1 out_vld", out_vld, 0);

      // R4 directed: only module 1 carries current
      v_ref = 0; v_meas = 0; i_meas1 = 16'sd400; i_meas2 = 0;
      sample("R4 cross");
      chk("R4 duty1 from i_meas2", duty1, 0);
      chk("R4 duty2 from i_meas1", duty2, -200);
      chk("R1 prop-only iref", iref, 0);
      @(negedge clk);
      chk("R8 pulse one cycle", out_vld, 0);

      // R2: negative samples floor downward (-1*13>>8 = -1)
      v_meas = 0; i_meas1 = 0; i_meas2 = -16'sd1;
      sample("R2 floor");

      // R8: no strobe means outputs hold while inputs move
      v_ref = 16'sd5000; i_meas1 = 16'sd9000; i_meas2 = -16'sd9000;
      repeat (5) @(negedge clk);
      chk("R8 hold iref", iref, e_iref);
      chk("R8 hold duty1", duty1, e_d1);
      chk("R8 hold duty2", duty2, e_d2);

      // R6/R7 start-up: large error saturates every loop
      do_reset();
      ref_lo = -16'sd2000; ref_hi = 16'sd2000; duty_lo = -16'sd1000; duty_hi = 16'sd1000;
      v_ref = 16'sd3000; v_meas = 0; i_meas1 = 0; i_meas2 = 0;
      for (int n = 0; n < 40; n++) sample("R6 startup");
      chk("R6 iref at high limit", iref, 2000);
      chk("R6 duty1 at high limit", duty1, 1000);
      // release: vfb = 30000*26>>8 = 3046, e = -46, prop = -184
      v_meas = 16'sd30000;
      sample("R7 release");
      chk("R7 no windup iref", iref, -184);
      chk("R6 duty2 at low limit", duty2, -1000);

      // random samples with random limits
      do_reset();
      for (int n = 0; n < 400; n++) begin
         if (n % 50 == 0) begin
            ref_lo  = -16'($urandom_range(2000, 0));
            ref_hi  = 16'($urandom_range(2000, 1));
            duty_lo = -16'($urandom_range(500, 0));
            duty_hi = 16'($urandom_range(3000, 1));
         end
         v_ref   = 16'($urandom_range(6000, 0));
         v_meas  = 16'($urandom_range(65535, 0));
         i_meas1 = 16'($urandom_range(65535, 0));
         i_meas2 = 16'($urandom_range(65535, 0));
         sample("R5 random");
         if (n % 37 == 0) begin
            @(negedge clk);
            chk("R8 pulse ends", out_vld, 0);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule